// File: doc/BRIEF.md
# I2C Controller Interrupt Status Collector

This block holds the raw interrupt status vector of an I2C controller. It turns event pulses from the bus engines, FIFO levels and thresholds, and the enable and idle flags into thirteen raw status bits. Some of these bits follow a level and some are sticky. It then masks them into a final status vector and a single combined interrupt line. The register decoder raises per-source clear strobes, or a global clear strobe, when software reads the matching clear location. The FIFOs, the bus state machines and the register decoding sit outside this block.

Each sticky bit has a disable rule. The activity bit drops as soon as software clears the enable bit. The other sticky bits keep their value until the controller's effective enable output falls, which happens once both engines are idle. The two level bits are recomputed on every cycle. Transmit-empty can be made to wait until the shift register has finished the last popped command. While the controller is disabled, transmit-empty reports whether either engine is still busy.

Top module: `i2c_irq_status`

## Requirements
- R1: On a clock edge with `rst` high, `raw_o`, `stat_o` and `irq_o` become all zero.
- R2: The raw vector is laid out as follows: bit 0 rx-underflow, 1 rx-overflow, 2 rx-full, 3 tx-overflow, 4 tx-empty, 5 read-request, 6 tx-abort, 7 rx-done, 8 activity, 9 stop-detect, 10 start-detect, 11 general-call, 12 restart-detect. Every bit except 2 and 4 is sticky. A one-cycle event pulse sets it at the next edge, and it keeps its value while no clear strobe arrives and its disable condition is inactive.
- R3: `clr_src_i[k]` clears sticky bit k at the next edge, and `clr_all_i` clears every sticky bit. Bits 2 and 4 ignore both strobes.
- R4: When a set event and a clear strobe reach the same sticky bit in one cycle, the bit is 1 after the edge.
- R5: When `ctl_en_i` is 1, bit 2 is 1 one cycle after `rx_lvl_i >= rx_thr_i` and 0 otherwise. When `ctl_en_i` is 0, bit 2 is 0.
- R6: When `ctl_en_i` is 1, bit 4 is 1 one cycle after `tx_lvl_i <= tx_thr_i`. If `txe_wait_shift_i` is 1, it additionally requires `tx_shift_done_i`.
- R7: When `ctl_en_i` is 0, bit 4 is `mst_busy_i | slv_busy_i` delayed by one cycle.
- R8: The activity bit (8) is cleared, and ignores new activity pulses, on every edge where `ctl_en_i` is 0.
- R9: Sticky bits other than 8 keep their value while `hw_en_i` is 1, even if `ctl_en_i` is 0. They are cleared, and ignore events, on every edge where `hw_en_i` is 0. Disable takes precedence over set.
- R10: A stop pulse sets bit 9 unless `stop_slave_ctx_i` and `stop_addr_only_i` are both 1 and `slv_addressed_i` is 0. A general-call match does not drive `slv_addressed_i`.
- R11: When `rx_hold_i` is 1, rx-overflow pulses do not set bit 1.
- R12: `stat_o` equals the previous cycle's `raw_o` AND the `mask_i` sampled at the same edge, and `irq_o` is the OR of those bits. Both are registered one cycle behind `raw_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en_i | input | 1 | Software enable bit |
| hw_en_i | input | 1 | Effective enable; falls once the engines are idle after disable |
| mst_busy_i | input | 1 | Master engine not idle |
| slv_busy_i | input | 1 | Slave engine not idle |
| txe_wait_shift_i | input | 1 | Tx-empty also waits for the shift register to finish |
| rx_hold_i | input | 1 | Receive-hold option; suppresses rx-overflow |
| stop_addr_only_i | input | 1 | In slave context, report stop only when addressed |
| rx_lvl_i | input | LVL_W | Receive FIFO fill level |
| rx_thr_i | input | LVL_W | Receive threshold |
| tx_lvl_i | input | LVL_W | Transmit FIFO fill level |
| tx_thr_i | input | LVL_W | Transmit threshold |
| tx_shift_done_i | input | 1 | Last popped command has been shifted out |
| rx_under_p_i | input | 1 | Rx underflow pulse |
| rx_over_p_i | input | 1 | Rx overflow pulse |
| tx_over_p_i | input | 1 | Tx overflow pulse |
| rd_req_p_i | input | 1 | Read request pulse |
| tx_abrt_p_i | input | 1 | Transmit abort pulse |
| rx_done_p_i | input | 1 | Slave-transmit done pulse |
| activity_p_i | input | 1 | Bus activity pulse |
| stop_p_i | input | 1 | Stop condition pulse |
| stop_slave_ctx_i | input | 1 | The stop belongs to a slave-mode transfer |
| slv_addressed_i | input | 1 | Slave own address matched in this transfer |
| start_p_i | input | 1 | Start condition pulse |
| restart_p_i | input | 1 | Restart detected while addressed |
| gcall_p_i | input | 1 | General call acknowledged pulse |
| clr_src_i | input | 13 | Per-source clear strobes, indexed by raw bit |
| clr_all_i | input | 1 | Global clear strobe |
| mask_i | input | 13 | Interrupt mask, 1 = enabled |
| raw_o | output | 13 | Raw status vector |
| stat_o | output | 13 | Masked status vector |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `LVL_W = 3`, so levels and thresholds range over 0 to 7. With that range, random level/threshold pairs land on the equality boundary of both comparisons often. The long random phase therefore crosses the at-or-above and at-or-below edges many times in every disable state. It also produces coincident set and clear strobes, and enable drops with and without busy engines, at a high rate.

// File: rtl/i2c_intr_pkg.sv
package i2c_intr_pkg;
  localparam int NSRC     = 13;
  localparam int B_RXUND  = 0;
  localparam int B_RXOVF  = 1;
  localparam int B_RXFULL = 2;
  localparam int B_TXOVF  = 3;
  localparam int B_TXEMP  = 4;
  localparam int B_RDREQ  = 5;
  localparam int B_TXABRT = 6;
  localparam int B_RXDONE = 7;
  localparam int B_ACT    = 8;
  localparam int B_STOP   = 9;
  localparam int B_START  = 10;
  localparam int B_GCALL  = 11;
  localparam int B_RSTRT  = 12;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/intr_level_src.sv
// Combinational next-value logic for the two level-derived status bits.
module intr_level_src #(
  parameter int LVL_W = 5
) (
  input  logic             en_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic             wait_shift_i,
  input  logic             shift_done_i,
  input  logic             busy_i,
  output logic             rx_full_nxt_o,
  output logic             tx_empty_nxt_o
);
  logic rx_at_thr;
  logic tx_below_thr;
  logic tx_ready;

  always_comb begin
    rx_at_thr    = (rx_lvl_i >= rx_thr_i);
    tx_below_thr = (tx_lvl_i <= tx_thr_i);
    tx_ready     = tx_below_thr & (~wait_shift_i | shift_done_i);
  end

  always_comb begin
    rx_full_nxt_o  = en_i & rx_at_thr;
    tx_empty_nxt_o = en_i ? tx_ready : busy_i;
  end
endmodule

// File: rtl/intr_sticky_bit.sv
// One sticky status bit: disable dominates, then set, then clear.
module intr_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic dis_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst || dis_i) q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
  end

  // R4: set beats a simultaneous clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i && !dis_i) |=> q_o);

  // R2: a set bit stays set without clear or disable
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i && !dis_i) |=> q_o);

  // R3: a clear alone drops the bit
  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);

  // R9 (and R8 for the activity bit): disable forces zero, even with a set
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
    dis_i |=> !q_o);
endmodule

// File: rtl/intr_mask_combine.sv
// Registered mask stage and combined interrupt line.
module intr_mask_combine #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] masked;

  always_comb masked = raw_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= masked;
      irq_o  <= |masked;
    end
  end

  // R12: no status bit survives a cleared mask bit
  assert_stat_masked_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_o & ~$past(mask_i)) == '0));

  // R12: any enabled raw bit raises the interrupt one cycle later
  assert_irq_follows_R12: assert property (@(posedge clk) disable iff (rst)
    (|(raw_i & mask_i)) |=> irq_o);

  // R12: the interrupt is low when nothing enabled was pending
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    ((raw_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_intr_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_en_i,
  input  logic             hw_en_i,
  input  logic             mst_busy_i,
  input  logic             slv_busy_i,
  input  logic             txe_wait_shift_i,
  input  logic             rx_hold_i,
  input  logic             stop_addr_only_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic             tx_shift_done_i,
  input  logic             rx_under_p_i,
  input  logic             rx_over_p_i,
  input  logic             tx_over_p_i,
  input  logic             rd_req_p_i,
  input  logic             tx_abrt_p_i,
  input  logic             rx_done_p_i,
  input  logic             activity_p_i,
  input  logic             stop_p_i,
  input  logic             stop_slave_ctx_i,
  input  logic             slv_addressed_i,
  input  logic             start_p_i,
  input  logic             restart_p_i,
  input  logic             gcall_p_i,
  input  logic [12:0]      clr_src_i,
  input  logic             clr_all_i,
  input  logic [12:0]      mask_i,
  output logic [12:0]      raw_o,
  output logic [12:0]      stat_o,
  output logic             irq_o
);
  // nxt_v carries the event for sticky slots and the next level for level slots
  src_vec_t nxt_v;
  src_vec_t clr_v;
  src_vec_t raw_q;
  logic     rx_full_nxt;
  logic     tx_empty_nxt;
  logic     stop_ok;

  intr_level_src #(.LVL_W(LVL_W)) u_level (
    .en_i          (ctl_en_i),
    .rx_lvl_i      (rx_lvl_i),
    .rx_thr_i      (rx_thr_i),
    .tx_lvl_i      (tx_lvl_i),
    .tx_thr_i      (tx_thr_i),
    .wait_shift_i  (txe_wait_shift_i),
    .shift_done_i  (tx_shift_done_i),
    .busy_i        (mst_busy_i | slv_busy_i),
    .rx_full_nxt_o (rx_full_nxt),
    .tx_empty_nxt_o(tx_empty_nxt)
  );

  always_comb begin
    stop_ok = stop_p_i & ~(stop_slave_ctx_i & stop_addr_only_i & ~slv_addressed_i);
    nxt_v           = '0;
    nxt_v[B_RXUND]  = rx_under_p_i;
    nxt_v[B_RXOVF]  = rx_over_p_i & ~rx_hold_i;
    nxt_v[B_RXFULL] = rx_full_nxt;
    nxt_v[B_TXOVF]  = tx_over_p_i;
    nxt_v[B_TXEMP]  = tx_empty_nxt;
    nxt_v[B_RDREQ]  = rd_req_p_i;
    nxt_v[B_TXABRT] = tx_abrt_p_i;
    nxt_v[B_RXDONE] = rx_done_p_i;
    nxt_v[B_ACT]    = activity_p_i;
    nxt_v[B_STOP]   = stop_ok;
    nxt_v[B_START]  = start_p_i;
    nxt_v[B_GCALL]  = gcall_p_i;
    nxt_v[B_RSTRT]  = restart_p_i;
    clr_v = clr_src_i | {NSRC{clr_all_i}};
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    logic q;
    if (k == B_RXFULL || k == B_TXEMP) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt_v[k];
      end
    end else begin : g_sticky
      logic dis;
      if (k == B_ACT) begin : g_sw_dis
        assign dis = ~ctl_en_i;
      end else begin : g_hw_dis
        assign dis = ~hw_en_i;
      end
      intr_sticky_bit u_bit (
        .clk  (clk),
        .rst  (rst),
        .set_i(nxt_v[k]),
        .clr_i(clr_v[k]),
        .dis_i(dis),
        .q_o  (q)
      );
    end
    assign raw_q[k] = q;
  end

  intr_mask_combine #(.N(NSRC)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .raw_i (raw_q),
    .mask_i(mask_i),
    .stat_o(stat_o),
    .irq_o (irq_o)
  );

  assign raw_o = raw_q;

  // R11: with receive hold, overflow never rises
  assert_ovf_blocked_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_hold_i && !raw_o[B_RXOVF]) |=> !raw_o[B_RXOVF]);

  // R10: unaddressed slave-context stop is not reported when filtering
  assert_stop_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (stop_p_i && stop_slave_ctx_i && stop_addr_only_i && !slv_addressed_i
     && !raw_o[B_STOP]) |=> !raw_o[B_STOP]);

  // R3: clear strobes leave the level bits alone
  assert_rxfull_ignores_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_v[B_RXFULL] && ctl_en_i && rx_lvl_i >= rx_thr_i) |=> raw_o[B_RXFULL]);
  assert_txemp_ignores_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_v[B_TXEMP] && !ctl_en_i && (mst_busy_i || slv_busy_i)) |=> raw_o[B_TXEMP]);

  // R5: rx-full drops once software disables
  assert_rxfull_off_R5: assert property (@(posedge clk) disable iff (rst)
    !ctl_en_i |=> !raw_o[B_RXFULL]);

  // R7: disabled and idle engines give tx-empty low
  assert_txemp_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en_i && !mst_busy_i && !slv_busy_i) |=> !raw_o[B_TXEMP]);
endmodule

// File: tb/i2c_irq_status_test.sv
module i2c_irq_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst;
  logic ctl_en, hw_en, mst_busy, slv_busy, txe_wait, rx_hold, stop_addr_only;
  logic [LW-1:0] rx_lvl, rx_thr, tx_lvl, tx_thr;
  logic shift_done;
  logic p_rxund, p_rxovf, p_txovf, p_rdreq, p_txabrt, p_rxdone, p_act;
  logic p_stop, stop_slv, slv_addr, p_start, p_rstrt, p_gcall;
  logic [12:0] clr_src, mask;
  logic clr_all;
  logic [12:0] raw, stat;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [12:0] e_raw = '0;
  logic [12:0] e_stat = '0;
  logic e_irq = 1'b0;
  string e_tag [13];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_status #(.LVL_W(LW)) uut (
    .clk(clk), .rst(rst), .ctl_en_i(ctl_en), .hw_en_i(hw_en),
    .mst_busy_i(mst_busy), .slv_busy_i(slv_busy), .txe_wait_shift_i(txe_wait),
    .rx_hold_i(rx_hold), .stop_addr_only_i(stop_addr_only),
    .rx_lvl_i(rx_lvl), .rx_thr_i(rx_thr), .tx_lvl_i(tx_lvl), .tx_thr_i(tx_thr),
    .tx_shift_done_i(shift_done), .rx_under_p_i(p_rxund), .rx_over_p_i(p_rxovf),
    .tx_over_p_i(p_txovf), .rd_req_p_i(p_rdreq), .tx_abrt_p_i(p_txabrt),
    .rx_done_p_i(p_rxdone), .activity_p_i(p_act), .stop_p_i(p_stop),
    .stop_slave_ctx_i(stop_slv), .slv_addressed_i(slv_addr), .start_p_i(p_start),
    .restart_p_i(p_rstrt), .gcall_p_i(p_gcall), .clr_src_i(clr_src),
    .clr_all_i(clr_all), .mask_i(mask), .raw_o(raw), .stat_o(stat), .irq_o(irq)
  );

  // Behavioural reference: computed from the requirements at each edge.
  always @(posedge clk) begin
    logic [12:0] ev;
    logic [12:0] nraw;
    logic [12:0] nstat;
    logic nirq;
    bit stop_rep;
    stop_rep = p_stop && !(stop_slv && stop_addr_only && !slv_addr);
    ev = '0;
    ev[0] = p_rxund; ev[1] = p_rxovf && !rx_hold; ev[3] = p_txovf;
    ev[5] = p_rdreq; ev[6] = p_txabrt; ev[7] = p_rxdone; ev[8] = p_act;
    ev[9] = stop_rep; ev[10] = p_start; ev[11] = p_gcall; ev[12] = p_rstrt;
    if (rst) begin
      nraw = '0; nstat = '0; nirq = 1'b0;
      for (int k = 0; k < 13; k++) e_tag[k] = "R1";
    end else begin
      nstat = e_raw & mask;
      nirq = (nstat != 0);
      for (int k = 0; k < 13; k++) begin
        bit clr_k, dis_k;
        clr_k = clr_src[k] || clr_all;
        if (k == 2) begin
          nraw[k] = ctl_en && (rx_lvl >= rx_thr);
          e_tag[k] = "R5";
        end else if (k == 4) begin
          if (ctl_en) begin
            nraw[k] = (tx_lvl <= tx_thr) && (!txe_wait || shift_done);
            e_tag[k] = "R6";
          end else begin
            nraw[k] = mst_busy || slv_busy;
            e_tag[k] = "R7";
          end
        end else begin
          dis_k = (k == 8) ? !ctl_en : !hw_en;
          if (dis_k) begin
            nraw[k] = 1'b0;
            e_tag[k] = (k == 8) ? "R8" : "R9";
          end else if (ev[k]) begin
            nraw[k] = 1'b1;
            e_tag[k] = clr_k ? "R4" : (k == 9 ? "R10" : "R2");
          end else if (clr_k) begin
            nraw[k] = 1'b0;
            e_tag[k] = "R3";
          end else begin
            nraw[k] = e_raw[k];
            e_tag[k] = (k == 1 && rx_hold) ? "R11" : (k == 9 ? "R10" : "R2");
          end
        end
      end
    end
    e_raw = nraw;
    e_stat = nstat;
    e_irq = nirq;
    #1;
    if (!done) begin
      checks++;
      if (raw !== e_raw) begin
        fails++;
        for (int k = 0; k < 13; k++)
          if (raw[k] !== e_raw[k])
            $display("FAIL %s raw bit %0d: actual %b expected %b at %0t",
                     e_tag[k], k, raw[k], e_raw[k], $time);
      end
      checks++;
      if (stat !== e_stat) begin
        fails++;
        $display("FAIL R12 stat: actual %h expected %h at %0t", stat, e_stat, $time);
      end
      checks++;
      if (irq !== e_irq) begin
        fails++;
        $display("FAIL R12 irq: actual %b expected %b at %0t", irq, e_irq, $time);
      end
    end
  end

  task automatic idle_inputs();
    p_rxund = 0; p_rxovf = 0; p_txovf = 0; p_rdreq = 0; p_txabrt = 0;
    p_rxdone = 0; p_act = 0; p_stop = 0; p_start = 0; p_rstrt = 0; p_gcall = 0;
    clr_src = '0; clr_all = 0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; ctl_en = 0; hw_en = 0; mst_busy = 0; slv_busy = 0;
    txe_wait = 0; rx_hold = 0; stop_addr_only = 0;
    rx_lvl = 0; rx_thr = 1; tx_lvl = 3; tx_thr = 2; shift_done = 0;
    stop_slv = 0; slv_addr = 0; mask = '1;
    idle_inputs();
    tick(3);
    rst = 0;                               // R1 checked during reset cycles
    ctl_en = 1; hw_en = 1;
    tick(2);
    // R2: each sticky event sets its bit and holds
    p_rxund = 1; p_txovf = 1; p_rdreq = 1; p_txabrt = 1; p_rxdone = 1;
    p_act = 1; p_start = 1; p_gcall = 1; p_rstrt = 1; p_rxovf = 1; p_stop = 1;
    tick(1); idle_inputs(); tick(3);
    // R3: per-source clear, then global clear
    clr_src[5] = 1; tick(1); idle_inputs(); tick(1);
    clr_all = 1; tick(1); idle_inputs(); tick(1);
    // R4: set and clear together
    p_txabrt = 1; clr_src[6] = 1; clr_all = 1; tick(1); idle_inputs(); tick(2);
    // R5: rx level crossing threshold
    rx_thr = 4; rx_lvl = 3; tick(1); rx_lvl = 4; tick(1); rx_lvl = 7; tick(1);
    clr_all = 1; clr_src = '1; tick(1); idle_inputs(); rx_lvl = 2; tick(2);
    // R6: tx-empty with and without shift wait
    tx_thr = 2; tx_lvl = 2; tick(1); tx_lvl = 3; tick(1); tx_lvl = 0; tick(1);
    txe_wait = 1; shift_done = 0; tick(2); shift_done = 1; tick(2); txe_wait = 0;
    // R8/R9: disable with busy engines, then engines go idle
    p_act = 1; p_rxund = 1; tick(1); idle_inputs();
    ctl_en = 0; mst_busy = 1; tick(2);      // R7 busy -> tx-empty 1
    p_act = 1; p_txovf = 1; tick(1); idle_inputs(); tick(1);
    mst_busy = 0; slv_busy = 1; tick(1); slv_busy = 0; hw_en = 0; tick(2);
    p_gcall = 1; tick(1); idle_inputs(); tick(1);
    ctl_en = 1; hw_en = 1; tick(2);
    // R10: stop filtering variants
    stop_addr_only = 1; stop_slv = 1; slv_addr = 0; p_stop = 1; tick(1); idle_inputs(); tick(1);
    slv_addr = 1; p_stop = 1; tick(1); idle_inputs(); clr_src[9] = 1; tick(1); idle_inputs();
    stop_slv = 0; slv_addr = 0; p_stop = 1; tick(1); idle_inputs(); tick(1);
    // R11: receive hold suppresses overflow
    rx_hold = 1; p_rxovf = 1; tick(1); idle_inputs(); tick(1); rx_hold = 0;
    // R12: masking
    p_rdreq = 1; tick(1); idle_inputs(); mask = '0; tick(2);
    mask = 13'h0020; tick(2); mask = 13'h1FDF; tick(2); mask = '1;
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      p_rxund = ($urandom % 8 == 0); p_rxovf = ($urandom % 8 == 0);
      p_txovf = ($urandom % 8 == 0); p_rdreq = ($urandom % 8 == 0);
      p_txabrt = ($urandom % 8 == 0); p_rxdone = ($urandom % 8 == 0);
      p_act = ($urandom % 6 == 0); p_stop = ($urandom % 6 == 0);
      p_start = ($urandom % 8 == 0); p_rstrt = ($urandom % 8 == 0);
      p_gcall = ($urandom % 8 == 0);
      stop_slv = $urandom % 2; slv_addr = $urandom % 2; stop_addr_only = $urandom % 2;
      clr_src = ($urandom % 4 == 0) ? 13'($urandom) : '0;
      clr_all = ($urandom % 16 == 0);
      rx_lvl = LW'($urandom); rx_thr = LW'($urandom);
      tx_lvl = LW'($urandom); tx_thr = LW'($urandom);
      txe_wait = $urandom % 2; shift_done = $urandom % 2; rx_hold = ($urandom % 4 == 0);
      mst_busy = ($urandom % 3 == 0); slv_busy = ($urandom % 4 == 0);
      if ($urandom % 32 == 0) ctl_en = ~ctl_en;
      hw_en = ctl_en || (hw_en && (mst_busy || slv_busy));
      if ($urandom % 20 == 0) mask = 13'($urandom);
      rst = ($urandom % 500 == 0);
    end
    @(negedge clk);
    rst = 0; idle_inputs();
    tick(3);
    finish_run();
  end
endmodule